// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Core

This block tracks requests and sets priority for an eight-line interrupt controller. Rising edges on the request pins are held in a pending register. Edges on masked lines are dropped. The higher a line's index, the higher its priority. A line in service blocks new requests from its own level and from all lower levels.

The block signals the processor with a one-cycle request pulse. When the processor acknowledges, the block picks the highest pending line and returns a vector built from the programmed base. If that line leads to a cascaded slave, it returns a flag instead, because the slave supplies the vector. An end-of-interrupt strobe retires one line from service. It also offers any request still pending to the processor again.

The register decode logic around the block programs it. It drives the mask, vector base, cascade map and automatic end-of-interrupt setting as levels. It reads the pending and in-service registers through the `irr` and `isr` ports.

Top module: `irq_prio_core`

## Requirements
- R1: A pending bit is set only when its pin changes from 0 to 1 between two clock edges. A pin that stays high sets nothing more until it has been low for at least one cycle.
- R2: A rising edge on a line whose `mask` bit is 1 is discarded. It never reaches `irr`.
- R3: When an unmasked edge on line L is latched, `int_req` pulses for one cycle, in the cycle after the edge is sampled. The pulse happens only if `isr` bits L through 7, after that cycle's update, are all zero.
- R4: An `ack` while `irr` is nonzero does three things. It clears the highest-indexed set `irr` bit. One cycle later it raises `vec_valid` with `vec_out = vec_base | L`, where the line index L sits in bits [2:0].
- R5: When `auto_eoi` is 0, an acknowledged line's `isr` bit is set.
- R6: When `auto_eoi` is 1, an acknowledge leaves `isr` unchanged. If `irr` is still nonzero afterwards, the highest pending line is offered again, following the rule in R8.
- R7: Suppose the acknowledged line has its `cascade_map` bit set and `slave_present` is 1. Then `vec_slave` is 1 and `vec_out` is 0. Otherwise `vec_slave` is 0.
- R8: `eoi_valid` clears `isr[eoi_line]`. If `irr` is then nonzero, `int_req` pulses in the next cycle. The pulse happens only if the updated `isr` bits from the highest pending index up to 7 are all zero.
- R9: An `ack` while `irr` is zero returns `vec_out = vec_base` with `vec_slave` = 0, and leaves `isr` unchanged.
- R10: After reset, `irr`, `isr`, `int_req` and `vec_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pins | input | 8 | Request pins, edge sensed |
| mask | input | 8 | Per-line mask, 1 drops edges |
| vec_base | input | 8 | Vector base, low three bits expected zero |
| cascade_map | input | 8 | Lines that lead to a cascaded slave |
| slave_present | input | 1 | A slave is attached |
| auto_eoi | input | 1 | Retire lines at acknowledge |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_line | input | 3 | Line retired by the strobe |
| ack | input | 1 | Acknowledge strobe |
| int_req | output | 1 | One-cycle request pulse |
| vec_valid | output | 1 | Vector result valid |
| vec_out | output | 8 | Returned vector |
| vec_slave | output | 1 | Slave supplies the vector |
| irr | output | 8 | Pending request register |
| isr | output | 8 | In-service register |

## Verification
The embedded assertions check the following on every cycle:
- new pending bits come only from unmasked rising edges;
- a request pulse always follows an event that could cause it;
- an acknowledged vector names the highest line that was pending;
- automatic end-of-interrupt never grows `isr`;
- an empty acknowledge returns the base.

Only the bench scenarios can show the rest: which request is blocked by a line in service, and when a retired line lets a waiting request through. They also show the mixed case where an acknowledge and a new edge fall in the same cycle under automatic end-of-interrupt, and how the cascade flag depends on `slave_present`.

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
  parameter int NLINES = 8,
  parameter int VW     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NLINES-1:0]         irq_pins,
  input  logic [NLINES-1:0]         mask,
  input  logic [VW-1:0]             vec_base,
  input  logic [NLINES-1:0]         cascade_map,
  input  logic                      slave_present,
  input  logic                      auto_eoi,
  input  logic                      eoi_valid,
  input  logic [$clog2(NLINES)-1:0] eoi_line,
  input  logic                      ack,
  output logic                      int_req,
  output logic                      vec_valid,
  output logic [VW-1:0]             vec_out,
  output logic                      vec_slave,
  output logic [NLINES-1:0]         irr,
  output logic [NLINES-1:0]         isr
);
  localparam int LW = $clog2(NLINES);

  function automatic logic [LW-1:0] top_bit(input logic [NLINES-1:0] v);
    logic [LW-1:0] t;
    t = '0;
    for (int i = 0; i < NLINES; i++)
      if (v[i]) t = LW'(i);
    return t;
  endfunction

  logic [NLINES-1:0] pin_q;
  logic [NLINES-1:0] latch;
  logic [LW-1:0]     sel;
  logic              ack_hit;
  logic [NLINES-1:0] sel_oh, irr_n, isr_n, isr_set, isr_clr;
  logic              eoi_evt, fwd_new, fwd_old, req_d;

  assign latch   = irq_pins & ~pin_q & ~mask;
  assign sel     = top_bit(irr);
  assign ack_hit = ack && (irr != '0);
  assign sel_oh  = ack_hit ? (NLINES'(1) << sel) : '0;
  assign irr_n   = (irr & ~sel_oh) | latch;
  assign isr_set = auto_eoi ? '0 : sel_oh;
  assign isr_clr = (eoi_valid ? (NLINES'(1) << eoi_line) : '0) | (auto_eoi ? sel_oh : '0);
  assign isr_n   = (isr | isr_set) & ~isr_clr;
  assign eoi_evt = eoi_valid || (ack_hit && auto_eoi);

  always_comb begin
    fwd_new = 1'b0;
    for (int i = 0; i < NLINES; i++)
      if (latch[i] && ((isr_n >> i) == '0)) fwd_new = 1'b1;
  end

  assign fwd_old = eoi_evt && (irr_n != '0) && ((isr_n >> top_bit(irr_n)) == '0);
  assign req_d   = fwd_new || fwd_old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q     <= '0;
      irr       <= '0;
      isr       <= '0;
      int_req   <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
      vec_slave <= 1'b0;
    end else begin
      pin_q     <= irq_pins;
      irr       <= irr_n;
      isr       <= isr_n;
      int_req   <= req_d;
      vec_valid <= ack;
      if (ack) begin
        if (ack_hit && cascade_map[sel] && slave_present) begin
          vec_out   <= '0;
          vec_slave <= 1'b1;
        end else begin
          vec_out   <= vec_base | {{(VW-LW){1'b0}}, (ack_hit ? sel : LW'(0))};
          vec_slave <= 1'b0;
        end
      end
    end
  end

  assert_edge_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (irr & ~$past(irr) & ~($past(irq_pins) & ~$past(pin_q))) == '0);

  assert_mask_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irr & ~$past(irr) & $past(mask)) == '0);

  assert_req_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> $past(((irq_pins & ~mask) != '0) || eoi_valid || (ack && auto_eoi)));

  assert_ack_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid);

  assert_ack_highest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack && (irr != '0)) && !vec_slave) |-> (($past(irr) >> vec_out[LW-1:0]) == 1));

  assert_auto_isr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(auto_eoi) |-> ((isr & ~$past(isr)) == '0));

  assert_empty_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ack && (irr == '0) && !eoi_valid) |-> ((isr == $past(isr)) && (vec_out == $past(vec_base)) && !vec_slave));
endmodule

// File: tb/sim_irq_prio_core.sv
module sim_irq_prio_core;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 18;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_pins = '0, mask = '0, vec_base = 8'h20, cascade_map = 8'h04;
  logic       slave_present = 1'b1, auto_eoi = 1'b0, eoi_valid = 1'b0, ack = 1'b0;
  logic [2:0] eoi_line = '0;
  logic       int_req, vec_valid, vec_slave;
  logic [7:0] vec_out, irr, isr;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_core u0 (
    .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins), .mask(mask), .vec_base(vec_base),
    .cascade_map(cascade_map), .slave_present(slave_present), .auto_eoi(auto_eoi),
    .eoi_valid(eoi_valid), .eoi_line(eoi_line), .ack(ack), .int_req(int_req),
    .vec_valid(vec_valid), .vec_out(vec_out), .vec_slave(vec_slave), .irr(irr), .isr(isr)
  );

  // pins mask ack eoi eline aeoi | irr isr req vv vec slv
  localparam logic [48:0] TBL [0:NROWS-1] = '{
    {8'h01, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h01, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0},
    {8'h01, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0},
    {8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 8'h01, 1'b0, 1'b1, 8'h20, 1'b0},
    {8'h08, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h08, 8'h01, 1'b1, 1'b0, 8'h00, 1'b0},
    {8'h80, 8'h80, 1'b0, 1'b0, 3'd0, 1'b0, 8'h08, 8'h01, 1'b0, 1'b0, 8'h00, 1'b0},
    {8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 8'h09, 1'b0, 1'b1, 8'h23, 1'b0},
    {8'h02, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h02, 8'h09, 1'b0, 1'b0, 8'h00, 1'b0},
    {8'h00, 8'h00, 1'b0, 1'b1, 3'd3, 1'b0, 8'h02, 8'h01, 1'b1, 1'b0, 8'h00, 1'b0},
    {8'h00, 8'h00, 1'b0, 1'b1, 3'd0, 1'b0, 8'h02, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0},
    {8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 8'h02, 1'b0, 1'b1, 8'h21, 1'b0},
    {8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 8'h02, 1'b0, 1'b1, 8'h20, 1'b0},
    {8'h04, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h04, 8'h02, 1'b1, 1'b0, 8'h00, 1'b0},
    {8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 8'h06, 1'b0, 1'b1, 8'h00, 1'b1},
    {8'h40, 8'h00, 1'b0, 1'b0, 3'd0, 1'b1, 8'h40, 8'h06, 1'b1, 1'b0, 8'h00, 1'b0},
    {8'h50, 8'h00, 1'b1, 1'b0, 3'd0, 1'b1, 8'h10, 8'h06, 1'b1, 1'b1, 8'h26, 1'b0},
    {8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 1'b1, 8'h00, 8'h06, 1'b0, 1'b1, 8'h24, 1'b0},
    {8'h00, 8'h00, 1'b0, 1'b1, 3'd2, 1'b0, 8'h00, 8'h02, 1'b0, 1'b0, 8'h00, 1'b0},
    {8'h00, 8'h00, 1'b0, 1'b1, 3'd1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0}
  };

  string tags [NROWS] = '{
    "R1 R3 first edge", "R1 held pin", "R4 R5 ack line0", "R3 edge above service",
    "R2 masked edge", "R4 R5 ack line3", "R3 blocked by service", "R8 eoi releases",
    "R8 eoi re-offer", "R4 ack line1", "R9 empty ack", "R3 edge line2",
    "R7 cascade ack", "R6 auto edge", "R6 auto ack with new edge", "R6 auto ack last",
    "R8 eoi line2", "R8 eoi line1"
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R10 reset irr", 32'(irr), 0);
    chk("R10 reset isr", 32'(isr), 0);
    chk("R10 reset req", 32'(int_req), 0);
    chk("R10 reset vec_valid", 32'(vec_valid), 0);

    for (int k = 0; k < NROWS; k++) begin
      irq_pins  = TBL[k][48:41];
      mask      = TBL[k][40:33];
      ack       = TBL[k][32];
      eoi_valid = TBL[k][31];
      eoi_line  = TBL[k][30:28];
      auto_eoi  = TBL[k][27];
      @(negedge clk);
      chk({tags[k], " irr"}, 32'(irr), 32'(TBL[k][26:19]));
      chk({tags[k], " isr"}, 32'(isr), 32'(TBL[k][18:11]));
      chk({tags[k], " int_req"}, 32'(int_req), 32'(TBL[k][10]));
      chk({tags[k], " vec_valid"}, 32'(vec_valid), 32'(TBL[k][9]));
      if (TBL[k][9]) begin
        chk({tags[k], " vec_out"}, 32'(vec_out), 32'(TBL[k][8:1]));
        chk({tags[k], " vec_slave"}, 32'(vec_slave), 32'(TBL[k][0]));
      end
    end
    ack = 1'b0; eoi_valid = 1'b0; auto_eoi = 1'b0; irq_pins = '0;

    // R7: cascade line without a slave gives the local vector
    slave_present = 1'b0;
    irq_pins = 8'h04;
    @(negedge clk);
    irq_pins = 8'h00; ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R7 no slave vec_out", 32'(vec_out), 32'h22);
    chk("R7 no slave flag", 32'(vec_slave), 0);
    chk("R5 no slave isr", 32'(isr), 32'h04);

    // R1: edge that appears while held-high pin is low again latches anew
    irq_pins = 8'h10;
    @(negedge clk);
    chk("R1 new edge irr", 32'(irr), 32'h10);
    chk("R3 line4 above service", 32'(int_req), 1);

    // R10: mid-run reset clears all state
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; irq_pins = '0;
    chk("R10 rerun irr", 32'(irr), 0);
    chk("R10 rerun isr", 32'(isr), 0);
    chk("R10 rerun req", 32'(int_req), 0);
    @(negedge clk);
    finish_run();
  end
endmodule